// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register-write front end of a programmable interrupt controller. It watches byte writes to two ports, a base port and a base+1 port, and runs the fixed four-step initialization: one base-port command followed by exactly three base+1 writes. Once the sequence is complete, writes go to the operation command registers. Those registers load the interrupt mask, rotate the lowest-priority level, pick which status register a read returns, and set or clear special mask mode.

A base-port write with data bit 4 set always restarts initialization, whatever the current state. The restart also resets the mask, the rotation, the slave id, the mask mode and the read selection. The latched vector base is joined with a 3-bit level input to form the vector byte that an acknowledge cycle elsewhere in the controller would use. Priority resolution, acknowledge cycles and cascading are outside this block.

Top module: `pic_init_seq`

## Requirements
- R1: A write with `wr_en`=1, `port_sel`=0 and `wr_data[4]`=1 is a start command in every state. One cycle later `seq_state` is 1 (waiting for the second word).
- R2: `seq_state` encodes 0 = ready, 1 = waiting for word 2, 2 = waiting for word 3, 3 = waiting for word 4. Each base+1 write moves the state 1→2, 2→3 and 3→0.
- R3: A start command sets `irq_mask` to 0x00, `lowest_prio` to 7, `slave_id` to 7, `spec_mask` to 0 and `read_isr` to 0 (request register selected).
- R4: If the start command has bit 0 = 0, `icw4_cfg` is cleared and the later fourth word leaves it at zero. If bit 0 = 1, the fourth word's bits 4:0 load `icw4_cfg`. Bits 3:1 of the start command have no effect.
- R5: The second word's bits 7:3 load `vec_base`. Its bits 2:0 are ignored.
- R6: The third word's bits 2:0 load `slave_id`.
- R7: `vector` equals `{vec_base, irq_level}` at all times.
- R8: In the ready state, a base+1 write loads all 8 bits of `wr_data` into `irq_mask`.
- R9: In the ready state, a base-port write with bit 4 = 0 and bit 3 = 0 is a rotate command. If bits 7:6 are both 1, `lowest_prio` takes bits 2:0. Otherwise nothing changes.
- R10: In the ready state, a base-port write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 1 = 1 loads `read_isr` from bit 0. Bit 6 = 1 loads `spec_mask` from bit 5.
- R11: While the sequence is in progress, base-port writes with bit 4 = 0 change neither the state nor any register.
- R12: After reset, `seq_state` is 0, `irq_mask` is 0xFF, `vec_base` is 0, `slave_id` is 7, `lowest_prio` is 7, `icw4_cfg` is 0, and `read_isr` and `spec_mask` are 0.
- R13: With `wr_en` = 0, no output changes, whatever the values on `port_sel` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| port_sel | input | 1 | 0 = base port, 1 = base+1 port |
| wr_data | input | 8 | Write data byte |
| irq_level | input | 3 | Level folded into the low bits of the vector |
| seq_state | output | 2 | Sequencer state (encoding in R2) |
| irq_mask | output | 8 | Interrupt mask register |
| vec_base | output | 5 | Latched vector base |
| vector | output | 8 | Vector base joined with the level |
| slave_id | output | 3 | Slave address |
| icw4_cfg | output | 5 | Mode bits from the fourth word |
| lowest_prio | output | 3 | Level that currently has the lowest priority |
| read_isr | output | 1 | 1 = status reads return the in-service register, 0 = the request register |
| spec_mask | output | 1 | Special mask mode enable |

## Verification
The random stream mixes start commands at arbitrary points, base+1 writes and bit-4-clear base writes. This separates a restart from a sequence step, and a step from an operation command, in every state. Directed sequences cover the following cases:
- A fourth word with IC4 cleared, to test its gating.
- Bits 2:0 of the second word set high, to confirm they are not latched.
- A rotate command without both top bits set.
- Mode commands with their enable bits cleared.
- Toggled data while the strobe is low.

Each of these cases isolates one way an ignored field could leak into a register.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 3;
  localparam int VB_W   = DATA_W - LVL_W;
  localparam int CFG_W  = 5;
  localparam int ST_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_READY = 2'd0,
    ST_WAIT2 = 2'd1,
    ST_WAIT3 = 2'd2,
    ST_WAIT4 = 2'd3
  } seq_state_t;

  // data bit positions decoded by this block
  localparam int B_START  = 4;
  localparam int B_OCWSEL = 3;
  localparam int B_IC4    = 0;
endpackage

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
  import pic_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic [DATA_W-1:0] wr_data,
  output seq_state_t        state,
  output logic              ic4_q,
  output logic              icw1_stb,
  output logic              icw2_stb,
  output logic              icw3_stb,
  output logic              icw4_stb,
  output logic              ocw1_stb,
  output logic              ocw2_stb,
  output logic              ocw3_stb
);
  seq_state_t state_nxt;
  logic       ic4_nxt;
  logic       base_wr, hi_wr, ready;

  assign base_wr = wr_en && !port_sel;
  assign hi_wr   = wr_en &&  port_sel;
  assign ready   = (state == ST_READY);

  // write decode
  always_comb begin
    icw1_stb = base_wr && wr_data[B_START];
    icw2_stb = hi_wr && (state == ST_WAIT2);
    icw3_stb = hi_wr && (state == ST_WAIT3);
    icw4_stb = hi_wr && (state == ST_WAIT4);
    ocw1_stb = hi_wr && ready;
    ocw2_stb = base_wr && !wr_data[B_START] && !wr_data[B_OCWSEL] && ready;
    ocw3_stb = base_wr && !wr_data[B_START] &&  wr_data[B_OCWSEL] && ready;
  end

  // next state
  always_comb begin
    state_nxt = state;
    ic4_nxt   = ic4_q;
    if (icw1_stb) begin
      state_nxt = ST_WAIT2;
      ic4_nxt   = wr_data[B_IC4];
    end else if (icw2_stb) begin
      state_nxt = ST_WAIT3;
    end else if (icw3_stb) begin
      state_nxt = ST_WAIT4;
    end else if (icw4_stb) begin
      state_nxt = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_READY;
      ic4_q <= 1'b0;
    end else if (wr_en) begin
      state <= state_nxt;
      ic4_q <= ic4_nxt;
    end
  end

  // R1
  start_to_wait2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && wr_data[B_START]) |=> (state == ST_WAIT2));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel && state != ST_READY) |=>
      (state == seq_state_t'(($past(state) + 2'd1) & 2'd3)));

  // R11
  midseq_base_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && !wr_data[B_START] && state != ST_READY) |=>
      (state == $past(state)));
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              icw1_stb,
  input  logic              icw2_stb,
  input  logic              icw3_stb,
  input  logic              icw4_stb,
  input  logic              ic4_q,
  output logic [VB_W-1:0]   vec_base,
  output logic [LVL_W-1:0]  slave_id,
  output logic [CFG_W-1:0]  icw4_cfg
);
  logic [VB_W-1:0]  vb_nxt;
  logic [LVL_W-1:0] sid_nxt;
  logic [CFG_W-1:0] cfg_nxt;
  logic             vb_en, sid_en, cfg_en;

  always_comb begin
    vb_en   = icw2_stb;
    vb_nxt  = wr_data[DATA_W-1:LVL_W];
    sid_en  = icw1_stb || icw3_stb;
    sid_nxt = icw1_stb ? {LVL_W{1'b1}} : wr_data[LVL_W-1:0];
    cfg_en  = (icw1_stb && !wr_data[B_IC4]) || (icw4_stb && ic4_q);
    cfg_nxt = icw1_stb ? '0 : wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_base <= '0;
      slave_id <= {LVL_W{1'b1}};
      icw4_cfg <= '0;
    end else begin
      if (vb_en)  vec_base <= vb_nxt;
      if (sid_en) slave_id <= sid_nxt;
      if (cfg_en) icw4_cfg <= cfg_nxt;
    end
  end

  // R5
  vec_base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icw2_stb |=> (vec_base == $past(wr_data[DATA_W-1:LVL_W])));

  // R4
  ic4_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icw4_stb && !ic4_q) |=> (icw4_cfg == '0));

  // R6
  slave_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icw3_stb |=> (slave_id == $past(wr_data[LVL_W-1:0])));
endmodule

// File: rtl/pic_ocw_regs.sv
module pic_ocw_regs
  import pic_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              icw1_stb,
  input  logic              ocw1_stb,
  input  logic              ocw2_stb,
  input  logic              ocw3_stb,
  output logic [DATA_W-1:0] irq_mask,
  output logic [LVL_W-1:0]  lowest_prio,
  output logic              read_isr,
  output logic              spec_mask
);
  logic              mask_en, prio_en, rd_en, smm_en;
  logic [DATA_W-1:0] mask_nxt;
  logic [LVL_W-1:0]  prio_nxt;
  logic              rd_nxt, smm_nxt;

  always_comb begin
    mask_en  = icw1_stb || ocw1_stb;
    mask_nxt = icw1_stb ? '0 : wr_data;
    prio_en  = icw1_stb || (ocw2_stb && wr_data[7] && wr_data[6]);
    prio_nxt = icw1_stb ? {LVL_W{1'b1}} : wr_data[LVL_W-1:0];
    rd_en    = icw1_stb || (ocw3_stb && wr_data[1]);
    rd_nxt   = icw1_stb ? 1'b0 : wr_data[0];
    smm_en   = icw1_stb || (ocw3_stb && wr_data[6]);
    smm_nxt  = icw1_stb ? 1'b0 : wr_data[5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask    <= '1;
      lowest_prio <= {LVL_W{1'b1}};
      read_isr    <= 1'b0;
      spec_mask   <= 1'b0;
    end else begin
      if (mask_en) irq_mask    <= mask_nxt;
      if (prio_en) lowest_prio <= prio_nxt;
      if (rd_en)   read_isr    <= rd_nxt;
      if (smm_en)  spec_mask   <= smm_nxt;
    end
  end

  // R3
  start_side_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_stb |=> (irq_mask == '0 && lowest_prio == {LVL_W{1'b1}} &&
                  !read_isr && !spec_mask));

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocw1_stb |=> (irq_mask == $past(wr_data)));

  // R9
  rotate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_stb && !(wr_data[7] && wr_data[6])) |=> $stable(lowest_prio));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  irq_level,
  output logic [ST_W-1:0]   seq_state,
  output logic [DATA_W-1:0] irq_mask,
  output logic [VB_W-1:0]   vec_base,
  output logic [DATA_W-1:0] vector,
  output logic [LVL_W-1:0]  slave_id,
  output logic [CFG_W-1:0]  icw4_cfg,
  output logic [LVL_W-1:0]  lowest_prio,
  output logic              read_isr,
  output logic              spec_mask
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sn;

  // asynchronous assert, synchronous release
  generate
    for (genvar i = 0; i < RST_STAGES; i++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[i] <= 1'b0;
        else        rst_pipe[i] <= (i == 0) ? 1'b1 : rst_pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign rst_sn = rst_pipe[RST_STAGES-1];

  seq_state_t st;
  logic ic4_q, icw1_stb, icw2_stb, icw3_stb, icw4_stb;
  logic ocw1_stb, ocw2_stb, ocw3_stb;

  pic_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .port_sel(port_sel),
    .wr_data(wr_data), .state(st), .ic4_q(ic4_q),
    .icw1_stb(icw1_stb), .icw2_stb(icw2_stb), .icw3_stb(icw3_stb),
    .icw4_stb(icw4_stb), .ocw1_stb(ocw1_stb), .ocw2_stb(ocw2_stb),
    .ocw3_stb(ocw3_stb)
  );

  pic_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_sn), .wr_data(wr_data),
    .icw1_stb(icw1_stb), .icw2_stb(icw2_stb), .icw3_stb(icw3_stb),
    .icw4_stb(icw4_stb), .ic4_q(ic4_q),
    .vec_base(vec_base), .slave_id(slave_id), .icw4_cfg(icw4_cfg)
  );

  pic_ocw_regs u_ocw (
    .clk(clk), .rst_n(rst_sn), .wr_data(wr_data),
    .icw1_stb(icw1_stb), .ocw1_stb(ocw1_stb), .ocw2_stb(ocw2_stb),
    .ocw3_stb(ocw3_stb), .irq_mask(irq_mask), .lowest_prio(lowest_prio),
    .read_isr(read_isr), .spec_mask(spec_mask)
  );

  assign seq_state = st;
  assign vector    = {vec_base, irq_level};

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_en |=> ($stable(seq_state) && $stable(irq_mask) && $stable(vec_base) &&
                $stable(slave_id) && $stable(icw4_cfg) && $stable(lowest_prio) &&
                $stable(read_isr) && $stable(spec_mask)));

  // R11
  midseq_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && !port_sel && !wr_data[B_START] && seq_state != 2'd0) |=>
      ($stable(irq_mask) && $stable(lowest_prio) && $stable(read_isr) &&
       $stable(spec_mask)));
endmodule

// File: tb/tb_pic_init_seq.sv
module tb_pic_init_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, port_sel;
  logic [7:0] wr_data;
  logic [2:0] irq_level;
  logic [1:0] seq_state;
  logic [7:0] irq_mask, vector;
  logic [4:0] vec_base, icw4_cfg;
  logic [2:0] slave_id, lowest_prio;
  logic       read_isr, spec_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model
  logic [1:0] m_st;
  logic [7:0] m_mask;
  logic [4:0] m_vb, m_cfg;
  logic [2:0] m_sid, m_prio;
  logic       m_rd, m_smm, m_ic4;

  always #4 clk = ~clk;

  pic_init_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
    .wr_data(wr_data), .irq_level(irq_level), .seq_state(seq_state),
    .irq_mask(irq_mask), .vec_base(vec_base), .vector(vector),
    .slave_id(slave_id), .icw4_cfg(icw4_cfg), .lowest_prio(lowest_prio),
    .read_isr(read_isr), .spec_mask(spec_mask)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic sel, logic [7:0] d, logic [1:0] st);
    if (!sel && d[4]) return "R3";
    if (sel) return (st == 2'd0) ? "R8" : "R2";
    if (st != 2'd0) return "R11";
    return d[3] ? "R10" : "R9";
  endfunction

  task automatic model_reset();
    m_st = 0; m_mask = 8'hFF; m_vb = 0; m_cfg = 0; m_sid = 7; m_prio = 7;
    m_rd = 0; m_smm = 0; m_ic4 = 0;
  endtask

  task automatic model_write(logic sel, logic [7:0] d);
    if (!sel && d[4]) begin
      m_st = 1; m_mask = 0; m_prio = 7; m_sid = 7; m_rd = 0; m_smm = 0;
      m_ic4 = d[0];
      if (!d[0]) m_cfg = 0;
    end else if (sel) begin
      case (m_st)
        2'd1: begin m_vb = d[7:3]; m_st = 2; end
        2'd2: begin m_sid = d[2:0]; m_st = 3; end
        2'd3: begin if (m_ic4) m_cfg = d[4:0]; m_st = 0; end
        default: m_mask = d;
      endcase
    end else if (m_st == 0) begin
      if (!d[3]) begin
        if (d[7] && d[6]) m_prio = d[2:0];
      end else begin
        if (d[1]) m_rd = d[0];
        if (d[6]) m_smm = d[5];
      end
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "seq_state", {6'd0, seq_state}, {6'd0, m_st});
    chk(req, "irq_mask", irq_mask, m_mask);
    chk(req, "vec_base", {3'd0, vec_base}, {3'd0, m_vb});
    chk(req, "slave_id", {5'd0, slave_id}, {5'd0, m_sid});
    chk(req, "icw4_cfg", {3'd0, icw4_cfg}, {3'd0, m_cfg});
    chk(req, "lowest_prio", {5'd0, lowest_prio}, {5'd0, m_prio});
    chk(req, "read_isr", {7'd0, read_isr}, {7'd0, m_rd});
    chk(req, "spec_mask", {7'd0, spec_mask}, {7'd0, m_smm});
    chk("R7", "vector", vector, {m_vb, irq_level});
  endtask

  task automatic wr(logic sel, logic [7:0] d, string req);
    @(negedge clk);
    wr_en = 1; port_sel = sel; wr_data = d; irq_level = 3'($urandom);
    @(negedge clk);
    wr_en = 0; wr_data = 8'($urandom); port_sel = 1'($urandom);
    model_write(sel, d);
    compare_all(req);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; wr_en = 0; port_sel = 0; wr_data = 0; irq_level = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R12");

    // directed: full init with IC4=1, vector low bits set to check ignoring
    wr(0, 8'h1F, "R1");
    chk("R1", "state after start", {6'd0, seq_state}, 8'd1);
    wr(1, 8'hAF, "R5");
    wr(1, 8'h05, "R6");
    wr(1, 8'h1D, "R4");
    chk("R4", "cfg loaded", {3'd0, icw4_cfg}, 8'h1D);
    // OCWs
    wr(1, 8'h5A, "R8");
    wr(0, 8'hC3, "R9");
    chk("R9", "rotate", {5'd0, lowest_prio}, 8'd3);
    wr(0, 8'h45, "R9");
    wr(0, 8'h0B, "R10");
    wr(0, 8'h68, "R10");
    wr(0, 8'h29, "R10");
    // restart with IC4=0: cfg cleared, 4th word ignored
    wr(0, 8'h10, "R3");
    chk("R3", "mask cleared", irq_mask, 8'h00);
    chk("R4", "cfg cleared", {3'd0, icw4_cfg}, 8'h00);
    wr(0, 8'h0E, "R11");
    wr(1, 8'h30, "R5");
    wr(0, 8'hE7, "R11");
    wr(1, 8'h02, "R6");
    wr(1, 8'h1F, "R4");
    chk("R4", "cfg stays zero", {3'd0, icw4_cfg}, 8'h00);
    // restart mid-sequence
    wr(0, 8'h11, "R1");
    wr(1, 8'h48, "R2");
    wr(0, 8'h13, "R1");
    chk("R1", "restart mid", {6'd0, seq_state}, 8'd1);
    // idle strobe, data toggling
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_data = 8'($urandom); port_sel = 1'($urandom);
    end
    compare_all("R13");

    // random
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      logic       s;
      int         r;
      r = $urandom % 16;
      d = 8'($urandom);
      s = 1'($urandom);
      if (r == 0) begin s = 0; d[4] = 1; end
      else if (!s && r < 12) d[4] = 0;
      wr(s, d, req_of(s, d, m_st));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule